// File: doc/BRIEF.md
# Decode-Stage Bypass and Hazard Stall Unit

This block resolves register data hazards for a five-stage in-order integer pipeline that reads and compares its operands in the decode stage. It looks at the two source register numbers of the instruction in decode. It also looks at the destination tag, write enable, valid flag and load flag of the instructions now in execute, memory and write-back. For each source operand it picks where the value comes from: the execute result, the memory-stage result, the value being written back in the same cycle, or the register file read port. It drives the selected operand value out directly.

When the producer of a needed value is a load that is still in execute, its data does not exist yet. The unit then asks the pipeline to hold the program counter and the fetch/decode register, and it injects an empty slot into execute. On the next cycle the load sits in memory and its data is forwarded from there. Register zero is hard-wired to zero and never creates a dependency.

Top module: `dec_hazard_unit`

## Requirements
- R1: When a valid, writing execute-stage instruction that is not a load targets a used source register, that operand's select is 3 (execute), the operand equals `ex_result`, and no stall is raised.
- R2: When the execute stage does not supply the register but a valid, writing memory-stage instruction does, the select is 2 (memory) and the operand equals `mem_result`. A load result in memory is forwarded this way.
- R3: When only the write-back stage writes the register, the select is 1 (write-back) and the operand equals `wb_data` in the same cycle.
- R4: When no stage writes the register, the select is 0 (register file) and the operand equals the matching register file read data.
- R5: When several stages write the same register, the youngest wins: execute before memory, memory before write-back.
- R6: Source register 0 never matches a producer. Its select is 0, its operand is zero, and it never causes a stall, even when a load in execute names register 0.
- R7: A valid load in execute whose destination matches a used source of a valid decode instruction raises `stall_fd` and `ex_bubble` together.
- R8: A producer that is not valid or has its write enable low creates no dependency. A source whose use flag is low never stalls.
- R9: With `id_valid` low, no stall and no bubble are raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used by the checks) |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_valid | input | 1 | Decode slot holds a real instruction |
| id_rs1 | input | 5 | First source register |
| id_rs2 | input | 5 | Second source register |
| id_use1 | input | 1 | First source is read |
| id_use2 | input | 1 | Second source is read |
| ex_valid | input | 1 | Execute slot occupied |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| ex_rd | input | 5 | Execute destination |
| ex_result | input | 32 | Execute ALU result |
| mem_valid | input | 1 | Memory slot occupied |
| mem_we | input | 1 | Memory instruction writes a register |
| mem_rd | input | 5 | Memory destination |
| mem_result | input | 32 | Memory-stage result (load data or ALU value) |
| wb_valid | input | 1 | Write-back slot occupied |
| wb_we | input | 1 | Write-back writes a register |
| wb_rd | input | 5 | Write-back destination |
| wb_data | input | 32 | Write-back value |
| rf_rdata1 | input | 32 | Register file data for first source |
| rf_rdata2 | input | 32 | Register file data for second source |
| fwd_sel1 | output | 2 | First operand source: 0 RF, 1 WB, 2 MEM, 3 EX |
| fwd_sel2 | output | 2 | Second operand source, same encoding |
| opnd1 | output | 32 | First operand value |
| opnd2 | output | 32 | Second operand value |
| stall_fd | output | 1 | Hold PC and fetch/decode register |
| ex_bubble | output | 1 | Send an empty slot into execute |

## Verification
The bench replays the load-use sequence over two cycles: the first with the load in execute, where a design that forwarded without stalling would hand decode stale data, and the second with the load in memory, where a design that kept stalling would waste a second cycle. Back-to-back ALU use must not stall, and the check would catch a unit that treats every execute match as a hazard. The two-apart and same-cycle write-back cases catch a missing memory path or write-through. Priority with all three stages naming one register exposes a reversed mux order. Register zero, disabled producers and unused sources catch false dependencies that would add bubbles.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int unsigned REG_AW = 5;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NSRC   = 2;

  typedef enum logic [1:0] {
    SEL_RF  = 2'd0,
    SEL_WB  = 2'd1,
    SEL_MEM = 2'd2,
    SEL_EX  = 2'd3
  } fwd_sel_e;
endpackage

// File: rtl/hz_src_select.sv
module hz_src_select
  import hz_pkg::*;
#(
  parameter int unsigned AW = REG_AW
) (
  input  logic          use_i,
  input  logic [AW-1:0] rs_i,
  input  logic          ex_valid_i,
  input  logic          ex_we_i,
  input  logic          ex_load_i,
  input  logic [AW-1:0] ex_rd_i,
  input  logic          mem_valid_i,
  input  logic          mem_we_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic          wb_valid_i,
  input  logic          wb_we_i,
  input  logic [AW-1:0] wb_rd_i,
  output fwd_sel_e      sel_o,
  output logic          load_hz_o
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic live;
  logic hit_ex, hit_mem, hit_wb;

  always_comb begin
    live    = use_i && (rs_i != ZERO_REG);
    hit_ex  = live && ex_valid_i  && ex_we_i  && (ex_rd_i  == rs_i);
    hit_mem = live && mem_valid_i && mem_we_i && (mem_rd_i == rs_i);
    hit_wb  = live && wb_valid_i  && wb_we_i  && (wb_rd_i  == rs_i);

    if (hit_ex)       sel_o = SEL_EX;
    else if (hit_mem) sel_o = SEL_MEM;
    else if (hit_wb)  sel_o = SEL_WB;
    else              sel_o = SEL_RF;

    load_hz_o = hit_ex && ex_load_i;
  end
endmodule

// File: rtl/hz_opnd_mux.sv
module hz_opnd_mux
  import hz_pkg::*;
#(
  parameter int unsigned AW = REG_AW,
  parameter int unsigned DW = DATA_W
) (
  input  fwd_sel_e      sel_i,
  input  logic [AW-1:0] rs_i,
  input  logic [DW-1:0] rf_i,
  input  logic [DW-1:0] wb_i,
  input  logic [DW-1:0] mem_i,
  input  logic [DW-1:0] ex_i,
  output logic [DW-1:0] opnd_o
);
  always_comb begin
    unique case (sel_i)
      SEL_EX:  opnd_o = ex_i;
      SEL_MEM: opnd_o = mem_i;
      SEL_WB:  opnd_o = wb_i;
      default: opnd_o = (rs_i == '0) ? '0 : rf_i;
    endcase
  end
endmodule

// File: rtl/hz_stall_ctl.sv
module hz_stall_ctl
  import hz_pkg::*;
#(
  parameter int unsigned N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         id_valid_i,
  input  logic [N-1:0] load_hz_i,
  input  logic         ex_valid_i,
  input  logic         ex_load_i,
  output logic         stall_o,
  output logic         bubble_o
);
  logic any_hz;

  always_comb begin
    any_hz   = |load_hz_i;
    stall_o  = id_valid_i && any_hz;
    bubble_o = stall_o;
  end

  // R7: a stall is only ever caused by a load sitting in execute
  a_r7_stall_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> (ex_valid_i && ex_load_i));

  // R9: an empty decode slot never stalls
  a_r9_idle_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid_i |-> !stall_o);
endmodule

// File: rtl/dec_hazard_unit.sv
module dec_hazard_unit
  import hz_pkg::*;
#(
  parameter int unsigned AW = REG_AW,
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          id_valid,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_use1,
  input  logic          id_use2,
  input  logic          ex_valid,
  input  logic          ex_we,
  input  logic          ex_load,
  input  logic [AW-1:0] ex_rd,
  input  logic [DW-1:0] ex_result,
  input  logic          mem_valid,
  input  logic          mem_we,
  input  logic [AW-1:0] mem_rd,
  input  logic [DW-1:0] mem_result,
  input  logic          wb_valid,
  input  logic          wb_we,
  input  logic [AW-1:0] wb_rd,
  input  logic [DW-1:0] wb_data,
  input  logic [DW-1:0] rf_rdata1,
  input  logic [DW-1:0] rf_rdata2,
  output logic [1:0]    fwd_sel1,
  output logic [1:0]    fwd_sel2,
  output logic [DW-1:0] opnd1,
  output logic [DW-1:0] opnd2,
  output logic          stall_fd,
  output logic          ex_bubble
);
  localparam int unsigned N = NSRC;

  logic [N-1:0][AW-1:0] rs_a;
  logic [N-1:0]         use_a;
  logic [N-1:0][DW-1:0] rf_a;
  logic [N-1:0][DW-1:0] opnd_a;
  fwd_sel_e             sel_a [N];
  logic [N-1:0]         load_hz_a;

  always_comb begin
    rs_a[0]  = id_rs1;    rs_a[1]  = id_rs2;
    use_a[0] = id_use1;   use_a[1] = id_use2;
    rf_a[0]  = rf_rdata1; rf_a[1]  = rf_rdata2;
  end

  for (genvar g = 0; g < N; g++) begin : g_src
    hz_src_select #(.AW(AW)) u_sel (
      .use_i      (use_a[g]),
      .rs_i       (rs_a[g]),
      .ex_valid_i (ex_valid),
      .ex_we_i    (ex_we),
      .ex_load_i  (ex_load),
      .ex_rd_i    (ex_rd),
      .mem_valid_i(mem_valid),
      .mem_we_i   (mem_we),
      .mem_rd_i   (mem_rd),
      .wb_valid_i (wb_valid),
      .wb_we_i    (wb_we),
      .wb_rd_i    (wb_rd),
      .sel_o      (sel_a[g]),
      .load_hz_o  (load_hz_a[g])
    );

    hz_opnd_mux #(.AW(AW), .DW(DW)) u_mux (
      .sel_i (sel_a[g]),
      .rs_i  (rs_a[g]),
      .rf_i  (rf_a[g]),
      .wb_i  (wb_data),
      .mem_i (mem_result),
      .ex_i  (ex_result),
      .opnd_o(opnd_a[g])
    );

    // R1: an execute-sourced operand carries the execute result
    a_r1_ex_value: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_a[g] == SEL_EX) |-> (opnd_a[g] == ex_result));

    // R6: register zero always reads as zero from the register file slot
    a_r6_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_a[g] == '0) |-> ((sel_a[g] == SEL_RF) && (opnd_a[g] == '0)));

    // R8: a disabled source never requests a stall
    a_r8_unused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !use_a[g] |-> !load_hz_a[g]);
  end

  hz_stall_ctl #(.N(N)) u_stall (
    .clk       (clk),
    .rst_n     (rst_n),
    .id_valid_i(id_valid),
    .load_hz_i (load_hz_a),
    .ex_valid_i(ex_valid),
    .ex_load_i (ex_load),
    .stall_o   (stall_fd),
    .bubble_o  (ex_bubble)
  );

  always_comb begin
    fwd_sel1 = sel_a[0];
    fwd_sel2 = sel_a[1];
    opnd1    = opnd_a[0];
    opnd2    = opnd_a[1];
  end

  // R7: holding decode always comes with an empty slot into execute
  a_r7_bubble_pair: assert property (@(posedge clk) disable iff (!rst_n)
    stall_fd |-> ex_bubble);
endmodule

// File: tb/dec_hazard_unit_test.sv
module dec_hazard_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        id_valid, id_use1, id_use2;
  logic [4:0]  id_rs1, id_rs2;
  logic        ex_valid, ex_we, ex_load;
  logic [4:0]  ex_rd;
  logic [31:0] ex_result;
  logic        mem_valid, mem_we;
  logic [4:0]  mem_rd;
  logic [31:0] mem_result;
  logic        wb_valid, wb_we;
  logic [4:0]  wb_rd;
  logic [31:0] wb_data, rf_rdata1, rf_rdata2;
  logic [1:0]  fwd_sel1, fwd_sel2;
  logic [31:0] opnd1, opnd2;
  logic        stall_fd, ex_bubble;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  dec_hazard_unit uut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic quiet();
    id_valid = 1; id_use1 = 1; id_use2 = 1; id_rs1 = 5'd1; id_rs2 = 5'd2;
    ex_valid = 0; ex_we = 0; ex_load = 0; ex_rd = 0; ex_result = 32'hE0E0_0001;
    mem_valid = 0; mem_we = 0; mem_rd = 0; mem_result = 32'hA0A0_0002;
    wb_valid = 0; wb_we = 0; wb_rd = 0; wb_data = 32'hB0B0_0003;
    rf_rdata1 = 32'h1111_1111; rf_rdata2 = 32'h2222_2222;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic t_reset_state();
    quiet(); step();
    chk("R4 sel1", fwd_sel1, 0); chk("R4 opnd1", opnd1, 32'h1111_1111);
    chk("R4 opnd2", opnd2, 32'h2222_2222); chk("R8 stall", stall_fd, 0);
  endtask

  task automatic t_alu_back_to_back();
    quiet(); ex_valid = 1; ex_we = 1; ex_rd = 5'd2; step();
    chk("R1 sel2", fwd_sel2, 3); chk("R1 opnd2", opnd2, 32'hE0E0_0001);
    chk("R1 no stall", stall_fd, 0); chk("R4 sel1", fwd_sel1, 0);
  endtask

  task automatic t_load_use();
    quiet(); ex_valid = 1; ex_we = 1; ex_load = 1; ex_rd = 5'd1; step();
    chk("R7 stall", stall_fd, 1); chk("R7 bubble", ex_bubble, 1);
    // next cycle: load moved to memory, bubble in execute
    ex_valid = 0; ex_load = 0; ex_we = 0;
    mem_valid = 1; mem_we = 1; mem_rd = 5'd1; mem_result = 32'hDA7A_0010; step();
    chk("R2 load sel1", fwd_sel1, 2); chk("R2 load opnd1", opnd1, 32'hDA7A_0010);
    chk("R2 no second stall", stall_fd, 0);
  endtask

  task automatic t_two_apart();
    quiet(); mem_valid = 1; mem_we = 1; mem_rd = 5'd2; step();
    chk("R2 sel2", fwd_sel2, 2); chk("R2 opnd2", opnd2, 32'hA0A0_0002);
  endtask

  task automatic t_wb_same_cycle();
    quiet(); wb_valid = 1; wb_we = 1; wb_rd = 5'd1; step();
    chk("R3 sel1", fwd_sel1, 1); chk("R3 opnd1", opnd1, 32'hB0B0_0003);
  endtask

  task automatic t_priority();
    quiet();
    ex_valid = 1; ex_we = 1; ex_rd = 5'd1;
    mem_valid = 1; mem_we = 1; mem_rd = 5'd1;
    wb_valid = 1; wb_we = 1; wb_rd = 5'd1; step();
    chk("R5 ex over mem", opnd1, 32'hE0E0_0001);
    ex_valid = 0; step();
    chk("R5 mem over wb", fwd_sel1, 2);
  endtask

  task automatic t_zero_reg();
    quiet(); id_rs1 = 0; ex_valid = 1; ex_we = 1; ex_load = 1; ex_rd = 0;
    rf_rdata1 = 32'hFFFF_FFFF; step();
    chk("R6 opnd1", opnd1, 0); chk("R6 sel1", fwd_sel1, 0); chk("R6 no stall", stall_fd, 0);
  endtask

  task automatic t_disabled();
    quiet(); ex_valid = 1; ex_we = 0; ex_rd = 5'd1; mem_valid = 0; mem_we = 1; mem_rd = 5'd2; step();
    chk("R8 we low", fwd_sel1, 0); chk("R8 invalid", fwd_sel2, 0);
    quiet(); id_use1 = 0; ex_valid = 1; ex_we = 1; ex_load = 1; ex_rd = 5'd1; step();
    chk("R8 unused no stall", stall_fd, 0);
  endtask

  task automatic t_idle_decode();
    quiet(); id_valid = 0; ex_valid = 1; ex_we = 1; ex_load = 1; ex_rd = 5'd2; step();
    chk("R9 stall", stall_fd, 0); chk("R9 bubble", ex_bubble, 0);
  endtask

  initial begin
    fork
      begin
        quiet(); rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset_state();
        t_alu_back_to_back();
        t_load_use();
        t_two_apart();
        t_wb_same_cycle();
        t_priority();
        t_zero_reg();
        t_disabled();
        t_idle_decode();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule